// File: doc/BRIEF.md
# Variable-Count Barrel Shifter

This block shifts one operand left or right, logically or arithmetically, in one pass through a log2(width) stage multiplexer network. The shift amount comes either from a full-width register operand or from a short immediate. When the register operand supplies the amount, a two-bit mode input sets how the bits above the natural shift range are handled: they can be ignored, one extra bit can saturate the result, every upper bit can be checked, or the low bits can be read as a signed amount whose sign picks the direction.

On the 64-bit build a narrow-word input shifts only the low 32 bits and returns that 32-bit result sign-extended into the full output, so older 32-bit code keeps its results on the wider datapath. A parameter chooses between a purely combinational output and one register stage.

Top module: `varshift`

## Requirements
- R1: With OUT_REG=1, `result` is all zeros while `rst_n` is low.
- R2: Mode 0 (wrap) with the register source shifts by the count modulo W; all higher count bits are ignored, so a count of 129 on a 32-bit build acts as a count of 1.
- R3: Mode 1 (extra bit) reads the count modulo 2W; a value from W to 2W-1 is out of range and yields the fill value, and counts at or above 2W wrap.
- R4: Mode 2 (full check) yields the fill value for any register count at or above W, and shifts by the count otherwise.
- R5: The out-of-range fill value is all zeros for a left or logical right shift, and copies of operand bit W-1 for an arithmetic right shift.
- R6: Mode 3 (signed) reads the low log2(W)+1 count bits as two's complement; a negative value shifts left by its magnitude (magnitude W gives zero), a non-negative value shifts right by it, and `go_right` is ignored.
- R7: With `use_imm` high, the amount is `cnt_imm` (modulo W), the mode and `cnt_reg` are ignored.
- R8: On a 64-bit build with `narrow32` high, only bits 31:0 are shifted, with bit 31 as the sign bit, by the selected count modulo 32 regardless of mode, and the 32-bit result is sign-extended into bits 63:32.
- R9: With OUT_REG=1 the result appears one clock after its inputs; with OUT_REG=0 it follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a | input | W | Value to shift |
| cnt_reg | input | W | Register-sourced shift amount |
| cnt_imm | input | log2(W) | Immediate shift amount |
| use_imm | input | 1 | 1 selects the immediate amount |
| go_right | input | 1 | 1 shifts right, 0 left (ignored in mode 3) |
| arith | input | 1 | 1 fills right shifts with the sign bit |
| cnt_mode | input | 2 | 0 wrap, 1 extra bit, 2 full check, 3 signed |
| narrow32 | input | 1 | 32-bit compatible shift (64-bit build only) |
| result | output | W | Shifted value |

## Verification
The bench builds two copies at once: a 64-bit one with the output register, which brings the narrow-word path and the one-cycle latency within reach, and a 32-bit combinational one, whose small count range lets every boundary from 0 through 2W and beyond fall inside the swept counts. Both are driven with the same sweep over every mode, source, direction and fill kind, against boundary counts and a handful of fixed and pseudo-random operands, with expected values computed bit by bit in the bench.

// File: rtl/varshift.sv
module varshift #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         opnd_a,
  input  logic [W-1:0]         cnt_reg,
  input  logic [$clog2(W)-1:0] cnt_imm,
  input  logic                 use_imm,
  input  logic                 go_right,
  input  logic                 arith,
  input  logic [1:0]           cnt_mode,
  input  logic                 narrow32,
  output logic [W-1:0]         result
);
  localparam int N = $clog2(W);

  typedef enum logic [1:0] {M_WRAP, M_EXTRA, M_FULL, M_SIGNED} mode_e;

  logic         nar, right, oor, fill;
  logic [N-1:0] amt;
  logic [N:0]   sv, mag;
  logic [W-1:0] op, din, out, res;
  logic [W-1:0] stg [N+1];

  assign sv  = cnt_reg[N:0];
  assign mag = ~sv + 1'b1;

  always_comb begin
    right = go_right;
    oor   = 1'b0;
    amt   = cnt_reg[N-1:0];
    if (nar) begin
      amt = N'(use_imm ? cnt_imm[4:0] : cnt_reg[4:0]);
    end else if (use_imm) begin
      amt = cnt_imm;
    end else begin
      case (mode_e'(cnt_mode))
        M_EXTRA: oor = cnt_reg[N];
        M_FULL:  oor = |cnt_reg[W-1:N];
        M_SIGNED: begin
          if (sv[N]) begin
            right = 1'b0;
            oor   = mag[N];
            amt   = mag[N-1:0];
          end else begin
            right = 1'b1;
            amt   = sv[N-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  generate
    if (W > 32) begin : g_nar
      assign nar = narrow32;
      assign op  = narrow32 ? {{(W-32){go_right & arith & opnd_a[31]}}, opnd_a[31:0]} : opnd_a;
    end else begin : g_wide
      logic unused_narrow;
      assign unused_narrow = narrow32;
      assign nar = 1'b0;
      assign op  = opnd_a;
    end
  endgenerate

  assign fill = right & arith & op[W-1];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_rev
      assign din[gi] = right ? op[gi] : op[W-1-gi];
      assign out[gi] = right ? stg[N][gi] : stg[N][W-1-gi];
    end
    assign stg[0] = din;
    for (gi = 0; gi < N; gi++) begin : g_stage
      assign stg[gi+1] = amt[gi] ? {{(2**gi){fill}}, stg[gi][W-1:2**gi]} : stg[gi];
    end
  endgenerate

  generate
    if (W > 32) begin : g_res_nar
      assign res = nar ? {{(W-32){out[31]}}, out[31:0]} : (oor ? {W{fill}} : out);
      a_r8_sext: assert property (@(posedge clk) disable iff (!rst_n)
        narrow32 |-> res[W-1:32] == {(W-32){res[31]}});
    end else begin : g_res_wide
      assign res = oor ? {W{fill}} : out;
    end
  endgenerate

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= res;
      end
      a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> result == $past(res));
    end else begin : g_comb
      assign result = res;
    end
  endgenerate

  a_r4_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!nar && !use_imm && cnt_mode == 2'd2 && |cnt_reg[W-1:N] && !(go_right && arith))
    |-> res == '0);

  a_r5_oor_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (!nar && !use_imm && cnt_mode == 2'd2 && |cnt_reg[W-1:N] && go_right && arith)
    |-> res == {W{opnd_a[W-1]}});

  a_r7_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!nar && use_imm && cnt_imm == '0) |-> res == opnd_a);

  a_r6_neg_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!nar && !use_imm && cnt_mode == 2'd3 && cnt_reg[N]) |-> res[0] == 1'b0);

endmodule

// File: tb/tb_varshift.sv
module tb_varshift;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [5:0]  imm = '0;
  logic        src = 1'b0, rt = 1'b0, ar = 1'b0, nw = 1'b0;
  logic [1:0]  md = '0;
  logic [63:0] y64;
  logic [31:0] y32;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  varshift #(.W(64), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .opnd_a(a), .cnt_reg(b), .cnt_imm(imm),
    .use_imm(src), .go_right(rt), .arith(ar), .cnt_mode(md),
    .narrow32(nw), .result(y64));

  varshift #(.W(32), .OUT_REG(1'b0)) dut32 (
    .clk(clk), .rst_n(rst_n), .opnd_a(a[31:0]), .cnt_reg(b[31:0]),
    .cnt_imm(imm[4:0]), .use_imm(src), .go_right(rt), .arith(ar),
    .cnt_mode(md), .narrow32(1'b0), .result(y32));

  function automatic logic [63:0] model(int w, logic [63:0] x, logic [63:0] c,
      logic [5:0] im, bit s, bit r_in, bit ari, int m, bit nar);
    logic [63:0] r;
    longint unsigned bm;
    int amt, ew, v;
    bit right, oor;
    logic fb;
    bm = (w == 32) ? (c & 64'hFFFF_FFFF) : c;
    right = r_in; oor = 0; ew = w; amt = 0;
    if (nar) begin
      ew = 32;
      amt = int'((s ? 64'(im) : bm) % 32);
    end else if (s) begin
      amt = int'(im) % w;
    end else begin
      case (m)
        0: amt = int'(bm % longint'(w));
        1: begin amt = int'(bm % longint'(2*w)); if (amt >= w) oor = 1; end
        2: begin if (bm >= longint'(w)) oor = 1; else amt = int'(bm); end
        default: begin
          v = int'(bm % longint'(2*w));
          if (v >= w) begin right = 0; amt = 2*w - v; if (amt == w) oor = 1; end
          else begin right = 1; amt = v; end
        end
      endcase
    end
    fb = (right && ari) ? x[ew-1] : 1'b0;
    r = '0;
    for (int i = 0; i < ew; i++) begin
      if (oor) r[i] = fb;
      else if (right) r[i] = (i + amt < ew) ? x[i+amt] : fb;
      else r[i] = (i >= amt) ? x[i-amt] : 1'b0;
    end
    if (nar) for (int i = 32; i < 64; i++) r[i] = r[31];
    return r;
  endfunction

  function automatic string tagof(bit s, bit nar, int m);
    if (nar) return "R8";
    if (s) return "R7";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] prev64;
  bit          have_prev = 0;

  task automatic run_vec(logic [63:0] x, logic [63:0] c, logic [5:0] im,
      bit s, bit r_in, bit ari, int m, bit nar);
    logic [63:0] e64, e32;
    a = x; b = c; imm = im; src = s; rt = r_in; ar = ari; md = 2'(m); nw = nar;
    e64 = model(64, x, c, im, s, r_in, ari, m, nar);
    e32 = model(32, x & 64'hFFFF_FFFF, c, im & 6'h1F, s, r_in, ari, m, 1'b0);
    #1;
    chk({tagof(s, 1'b0, m), " w32"}, {32'h0, y32}, e32);
    if (have_prev) chk("R9 hold", y64, prev64);
    @(negedge clk);
    chk({tagof(s, nar, m), " w64"}, y64, e64);
    prev64 = e64;
    have_prev = 1;
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] cnts [18];
    logic [63:0] ops [5];
    cnts = '{64'd0, 64'd1, 64'd5, 64'd31, 64'd32, 64'd33, 64'd63, 64'd64,
             64'd65, 64'd127, 64'd128, 64'd129, 64'hFFFF_FFFF,
             64'h1_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
             64'hFFFF_FFFF_FFFF_FFC0, 64'h7F, 64'h40};
    ops = '{64'h8000_0000_0000_0001, 64'hF0E1_D2C3_B4A5_9687,
            64'h0123_4567_89AB_CDEF, 64'h0000_0000_8765_4321, 64'h0};
    a = 64'hDEAD_BEEF_0000_FFFF; b = 64'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset", y64, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int oi = 0; oi < 5; oi++) begin
      logic [63:0] x;
      x = (oi == 4) ? {$urandom(), $urandom()} : ops[oi];
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 2; r++)
            for (int ari = 0; ari < 2; ari++)
              for (int nar = 0; nar < 2; nar++)
                for (int ci = 0; ci < 18; ci++)
                  run_vec(x, cnts[ci], 6'(cnts[ci] * 3 + 1), s[0], r[0], ari[0], m, nar[0]);
    end

    run_vec(64'h8000_0000_0000_0000, 64'd200, 6'd0, 0, 1, 1, 2, 0);
    chk("R5 sign fill", y64, 64'hFFFF_FFFF_FFFF_FFFF);
    run_vec(64'h8000_0000_0000_0000, 64'd200, 6'd0, 0, 1, 0, 2, 0);
    chk("R5 zero fill", y64, 64'h0);
    run_vec(64'h0000_0000_1234_5679, 64'd129, 6'd0, 0, 0, 0, 0, 0);
    chk("R2 129 as 1", {32'h0, y32}, 64'h0000_0000_2468_ACF2);
    run_vec(64'h0000_0000_8000_0000, 64'd4, 6'd0, 0, 1, 1, 0, 1);
    chk("R8 sext", y64, 64'hFFFF_FFFF_F800_0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule